// File: doc/BRIEF.md
# Packet Page Allocation Unit

This block keeps track of a small pool of equal-sized packet buffer pages inside an Ethernet controller. A bitmap records which pages are in use. Three shift-down queues of page numbers hold frames waiting to go out, frames that have gone out and wait for the host to reclaim them, and frames that have come in and wait for the host to read them. The host drives the block with 3-bit commands. It reads back the result of the last transmit allocation, the head of each queue and the number of pages in use. The receive side asks for pages on its own request line, and the transmit side reports each finished frame.

Interrupt status is kept here for four events: allocation done, frame received, frame transmitted, and transmit queue empty. A mask register decides which of them drive the interrupt line. An acknowledge write clears only the bits that may be acknowledged. When a transmit allocation fails it does not report an error and stop. It stays pending and completes by itself once a page is freed.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocation always takes the lowest-numbered free page. A granted transmit allocation shows the page number, zero-extended to 8 bits, on `alloc_result`. `pages_used` always equals the number of pages in use.
- R2: A transmit allocation with no free page shows 0x80 on `alloc_result` and clears status bit 3 (ALLOC). The request stays pending, and in the cycle after a page is freed it is granted, shows the page number and sets ALLOC.
- R3: `cmd_code` values: 0 does nothing, 1 allocates for transmit, 2 resets the unit, 3 pops the receive queue, 4 pops the receive queue and frees its head page, 5 frees page `pkt_num`, 6 appends `pkt_num` to the transmit queue, 7 empties the transmit queue and the transmitted queue.
- R4: A `rx_req` pulse takes the lowest free page, appends it to the receive queue and sets status bit 0 (RCV). With no page left the request is dropped. A transmit allocation in the same cycle is served first.
- R5: A receive pop leaves RCV set while entries remain and clears it once the queue is empty. A pop of an empty queue changes no queue and frees no page.
- R6: A `tx_sent` pulse removes the head of the transmit queue. If `auto_release` is high it frees that page; otherwise it appends the page to the transmitted queue.
- R7: Each queue holds one entry per page. A push to a full queue is dropped. A queue head reads as the page number, or 0x80 when the queue is empty.
- R8: Status bit 2 (TX_EMPTY) reads 1 whenever the transmit queue is empty and otherwise holds until it is acknowledged. Bit 1 (TX) reads 1 whenever the transmitted queue is non-empty.
- R9: An acknowledge write clears only the status bits in `ack_wdata & 0xD6`. If bit 1 of the write is set, it also removes one entry from the transmitted queue.
- R10: `irq` is high exactly when `int_status & int_mask` is non-zero. `int_mask` is loaded by `mask_we`.
- R11: After reset no page is in use, `alloc_result` is 0x00, all queue heads read 0x80, `int_status` is 0x04 and `int_mask` is 0x00.
- R12: Command 2 frees every page, empties all queues, sets `alloc_result` to 0x00 and cancels a pending allocation. It leaves the status flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (R3) |
| pkt_num | input | 2 | Host's current page number for release and enqueue |
| rx_req | input | 1 | Receive side asks for a page |
| tx_sent | input | 1 | Transmitter finished the head frame |
| auto_release | input | 1 | Free sent pages instead of queueing them |
| ack_we | input | 1 | Acknowledge strobe |
| ack_wdata | input | 8 | Status bits to acknowledge |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New interrupt mask |
| alloc_result | output | 8 | Last transmit allocation, 0x80 while pending |
| rx_head | output | 8 | Receive queue head or 0x80 |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| done_head | output | 8 | Transmitted queue head or 0x80 |
| pages_used | output | 3 | Count of pages in use |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a pending transmit allocation that wakes up. The stimulus first fills the pool through a mix of transmit allocations and receive requests. It then issues one more allocation, frees a single page, and checks that `alloc_result` still reads 0x80 until the following cycle. A second run of this sequence puts a receive request in the wake-up cycle, so the bench can check that the freed page goes to the transmit side and the receive request is dropped. The sticky TX_EMPTY flag also needs care. The stimulus acknowledges it while the transmit queue is non-empty, then drains the queue, and checks that the flag clears and comes back at the right points.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [2:0] {
        CMD_NOP         = 3'd0,
        CMD_TX_ALLOC    = 3'd1,
        CMD_UNIT_RESET  = 3'd2,
        CMD_RX_POP      = 3'd3,
        CMD_RX_POP_FREE = 3'd4,
        CMD_RELEASE     = 3'd5,
        CMD_TX_ENQ      = 3'd6,
        CMD_TX_CLEAR    = 3'd7
    } mmu_cmd_e;

    typedef struct packed {
        logic tx_alloc;
        logic unit_reset;
        logic rx_pop;
        logic rx_free;
        logic release_pkt;
        logic tx_enq;
        logic tx_clear;
    } cmd_dec_t;

    localparam logic [7:0] NO_PAGE_CODE = 8'h80;
    localparam logic [7:0] ACK_MASK     = 8'hD6;
    localparam int         ST_RCV       = 0;
    localparam int         ST_TX        = 1;
    localparam int         ST_TXE       = 2;
    localparam int         ST_ALLOC     = 3;

    function automatic cmd_dec_t decode_cmd(input logic valid, input mmu_cmd_e code);
        cmd_dec_t d;
        d = '0;
        if (valid) begin
            case (code)
                CMD_NOP:         d = '0;
                CMD_TX_ALLOC:    d.tx_alloc    = 1'b1;
                CMD_UNIT_RESET:  d.unit_reset  = 1'b1;
                CMD_RX_POP:      d.rx_pop      = 1'b1;
                CMD_RX_POP_FREE: d.rx_free     = 1'b1;
                CMD_RELEASE:     d.release_pkt = 1'b1;
                CMD_TX_ENQ:      d.tx_enq      = 1'b1;
                CMD_TX_CLEAR:    d.tx_clear    = 1'b1;
                default:         d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/pmu_page_pool.sv
module pmu_page_pool #(
    parameter int NUM_PAGES = 4,
    localparam int ID_W  = $clog2(NUM_PAGES),
    localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_all,
    input  logic [NUM_PAGES-1:0] free_mask,
    input  logic                 tx_req,
    input  logic                 rx_req,
    output logic                 tx_gnt,
    output logic [ID_W-1:0]      tx_idx,
    output logic                 rx_gnt,
    output logic [ID_W-1:0]      rx_idx,
    output logic [CNT_W-1:0]     used_cnt
);

    logic [NUM_PAGES-1:0] busy_q;
    logic [NUM_PAGES-1:0] tx_hot, rx_hot, taken;
    logic                 tx_found, rx_found;

    // Lowest free page for the transmit side (scan downward so lowest wins).
    always_comb begin
        tx_found = 1'b0;
        tx_idx   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                tx_found = 1'b1;
                tx_idx   = ID_W'(i);
            end
        end
    end

    assign tx_gnt = tx_req && tx_found;
    assign tx_hot = tx_gnt ? ({{(NUM_PAGES-1){1'b0}}, 1'b1} << tx_idx) : '0;
    assign taken  = busy_q | tx_hot;

    // Receive side searches what the transmit side left over.
    always_comb begin
        rx_found = 1'b0;
        rx_idx   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!taken[i]) begin
                rx_found = 1'b1;
                rx_idx   = ID_W'(i);
            end
        end
    end

    assign rx_gnt = rx_req && rx_found;
    assign rx_hot = rx_gnt ? ({{(NUM_PAGES-1){1'b0}}, 1'b1} << rx_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~free_mask) | tx_hot | rx_hot;
        end
    end

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            used_cnt = used_cnt + CNT_W'(busy_q[i]);
        end
    end

    // R1: a granted page is marked busy on the next cycle
    p_grant_held_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_gnt && !clear_all) |=> busy_q[$past(tx_idx)]);

    // R4: both sides never receive the same page in one cycle
    p_distinct_grant_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_gnt && rx_gnt) |-> (tx_idx != rx_idx));

endmodule

// File: rtl/pmu_page_queue.sv
module pmu_page_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    logic [W-1:0]  slot_q [DEPTH];
    logic [W-1:0]  slot_d [DEPTH];
    logic [CW-1:0] cnt_q, base;
    logic          pop_eff, push_eff;

    assign pop_eff  = pop && (cnt_q != '0);
    assign base     = cnt_q - CW'(pop_eff);
    assign push_eff = push && (base < CW'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] shifted;
        if (g < DEPTH - 1) begin : g_mid
            assign shifted = slot_q[g+1];
        end else begin : g_last
            assign shifted = '0;
        end
        assign slot_d[g] = (push_eff && base == CW'(g)) ? push_data
                         : (pop_eff ? shifted : slot_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            cnt_q <= base + CW'(push_eff);
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head  = slot_q[0];
    assign count = cnt_q;

    // R7: occupancy never exceeds the depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/pmu_irq_ctrl.sv
module pmu_irq_ctrl
    import pmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rcv_set,
    input  logic       rcv_clr,
    input  logic       alloc_set,
    input  logic       alloc_clr,
    input  logic       ack_we,
    input  logic [7:0] ack_wdata,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    input  logic       txq_empty,
    input  logic       done_nonempty,
    output logic [7:0] status,
    output logic [7:0] mask,
    output logic       irq
);

    logic [7:0] flags_q, forced, view, set_vec, clr_vec, ack_hit;
    logic [7:0] mask_q;

    always_comb begin
        forced          = '0;
        forced[ST_TXE]  = txq_empty;
        forced[ST_TX]   = done_nonempty;
        set_vec         = '0;
        set_vec[ST_RCV]   = rcv_set;
        set_vec[ST_ALLOC] = alloc_set;
        clr_vec         = '0;
        clr_vec[ST_RCV]   = rcv_clr;
        clr_vec[ST_ALLOC] = alloc_clr;
    end

    assign view    = flags_q | forced;
    assign ack_hit = ack_we ? (ack_wdata & ACK_MASK) : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (view & ~ack_hit & ~clr_vec) | set_vec;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign status = view;
    assign mask   = mask_q;
    assign irq    = |(view & mask_q);

    // R10: a cleared mask keeps the line low
    p_mask_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'h00) |-> !irq);

    // R8: transmit-empty is visible whenever the queue is empty
    p_txe_forced_r8: assert property (@(posedge clk) disable iff (rst)
        txq_empty |-> status[ST_TXE]);

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
    import pmu_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int ID_W  = $clog2(NUM_PAGES),
    localparam int CNT_W = $clog2(NUM_PAGES + 1),
    localparam int PAD_W = 8 - ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [2:0]       cmd_code,
    input  logic [ID_W-1:0]  pkt_num,
    input  logic             rx_req,
    input  logic             tx_sent,
    input  logic             auto_release,
    input  logic             ack_we,
    input  logic [7:0]       ack_wdata,
    input  logic             mask_we,
    input  logic [7:0]       mask_wdata,
    output logic [7:0]       alloc_result,
    output logic [7:0]       rx_head,
    output logic [7:0]       tx_head,
    output logic [7:0]       done_head,
    output logic [CNT_W-1:0] pages_used,
    output logic [7:0]       int_status,
    output logic [7:0]       int_mask,
    output logic             irq
);

    cmd_dec_t dec;
    assign dec = decode_cmd(cmd_we, mmu_cmd_e'(cmd_code));

    logic                 pending_q;
    logic [7:0]           result_q;
    logic                 tx_gnt, rx_gnt;
    logic [ID_W-1:0]      tx_idx, rx_idx;
    logic [NUM_PAGES-1:0] free_mask;
    logic [ID_W-1:0]      rxq_head, txq_head, doneq_head;
    logic [CNT_W-1:0]     rxq_cnt, txq_cnt, doneq_cnt;
    logic                 rx_pop_any, rx_free_eff, sent_eff, auto_free, done_push;

    assign rx_pop_any  = dec.rx_pop || dec.rx_free;
    assign rx_free_eff = dec.rx_free && (rxq_cnt != '0);
    assign sent_eff    = tx_sent && (txq_cnt != '0);
    assign auto_free   = sent_eff && auto_release;
    assign done_push   = sent_eff && !auto_release;

    always_comb begin
        free_mask = '0;
        if (rx_free_eff)     free_mask[rxq_head] = 1'b1;
        if (dec.release_pkt) free_mask[pkt_num]  = 1'b1;
        if (auto_free)       free_mask[txq_head] = 1'b1;
    end

    pmu_page_pool #(.NUM_PAGES(NUM_PAGES)) i_pool (
        .clk       (clk),
        .rst       (rst),
        .clear_all (dec.unit_reset),
        .free_mask (free_mask),
        .tx_req    (!dec.unit_reset && (dec.tx_alloc || pending_q)),
        .rx_req    (!dec.unit_reset && rx_req),
        .tx_gnt    (tx_gnt),
        .tx_idx    (tx_idx),
        .rx_gnt    (rx_gnt),
        .rx_idx    (rx_idx),
        .used_cnt  (pages_used)
    );

    // Pending transmit allocation and its visible result.
    always_ff @(posedge clk) begin
        if (rst || dec.unit_reset) begin
            pending_q <= 1'b0;
            result_q  <= 8'h00;
        end else if (tx_gnt) begin
            pending_q <= 1'b0;
            result_q  <= {{PAD_W{1'b0}}, tx_idx};
        end else if (dec.tx_alloc) begin
            pending_q <= 1'b1;
            result_q  <= NO_PAGE_CODE;
        end
    end

    assign alloc_result = result_q;

    pmu_page_queue #(.DEPTH(NUM_PAGES), .W(ID_W)) i_rxq (
        .clk       (clk),
        .rst       (rst),
        .clear     (dec.unit_reset),
        .push      (rx_gnt),
        .push_data (rx_idx),
        .pop       (rx_pop_any),
        .head      (rxq_head),
        .count     (rxq_cnt)
    );

    pmu_page_queue #(.DEPTH(NUM_PAGES), .W(ID_W)) i_txq (
        .clk       (clk),
        .rst       (rst),
        .clear     (dec.unit_reset || dec.tx_clear),
        .push      (dec.tx_enq),
        .push_data (pkt_num),
        .pop       (tx_sent),
        .head      (txq_head),
        .count     (txq_cnt)
    );

    pmu_page_queue #(.DEPTH(NUM_PAGES), .W(ID_W)) i_doneq (
        .clk       (clk),
        .rst       (rst),
        .clear     (dec.unit_reset || dec.tx_clear),
        .push      (done_push),
        .push_data (txq_head),
        .pop       (ack_we && ack_wdata[ST_TX]),
        .head      (doneq_head),
        .count     (doneq_cnt)
    );

    assign rx_head   = (rxq_cnt == '0)   ? NO_PAGE_CODE : {{PAD_W{1'b0}}, rxq_head};
    assign tx_head   = (txq_cnt == '0)   ? NO_PAGE_CODE : {{PAD_W{1'b0}}, txq_head};
    assign done_head = (doneq_cnt == '0) ? NO_PAGE_CODE : {{PAD_W{1'b0}}, doneq_head};

    pmu_irq_ctrl i_irq (
        .clk           (clk),
        .rst           (rst),
        .rcv_set       (rx_gnt),
        .rcv_clr       (rx_pop_any && (rxq_cnt <= CNT_W'(1))),
        .alloc_set     (tx_gnt),
        .alloc_clr     (dec.tx_alloc),
        .ack_we        (ack_we),
        .ack_wdata     (ack_wdata),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .txq_empty     (txq_cnt == '0),
        .done_nonempty (doneq_cnt != '0),
        .status        (int_status),
        .mask          (int_mask),
        .irq           (irq)
    );

    // R2: while a request is pending the result reads the no-page code
    p_pending_code_r2: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> (alloc_result == NO_PAGE_CODE));

    // R5: popping the last receive entry drops the receive flag
    p_rcv_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop_any && rxq_cnt == CNT_W'(1) && !rx_gnt) |=> !int_status[ST_RCV]);

endmodule

// File: tb/test_pkt_page_mgr.sv
`timescale 1ns/1ps
module test_pkt_page_mgr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd_code = '0;
    logic [1:0] pkt_num = '0;
    logic       rx_req = 1'b0, tx_sent = 1'b0, auto_release = 1'b0;
    logic       ack_we = 1'b0, mask_we = 1'b0;
    logic [7:0] ack_wdata = '0, mask_wdata = '0;
    logic [7:0] alloc_result, rx_head, tx_head, done_head, int_status, int_mask;
    logic [2:0] pages_used;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pkt_page_mgr i_pkt_page_mgr (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code), .pkt_num(pkt_num),
        .rx_req(rx_req), .tx_sent(tx_sent), .auto_release(auto_release),
        .ack_we(ack_we), .ack_wdata(ack_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .alloc_result(alloc_result), .rx_head(rx_head), .tx_head(tx_head),
        .done_head(done_head), .pages_used(pages_used), .int_status(int_status),
        .int_mask(int_mask), .irq(irq)
    );

    typedef struct packed {
        logic       cv;
        logic [2:0] code;
        logic [1:0] pkt;
        logic       rx;
        logic       ts;
        logic       av;
        logic [7:0] ack;
        logic [7:0] e_alloc;
        logic [7:0] e_rx;
        logic [7:0] e_tx;
        logic [7:0] e_done;
        logic [2:0] e_used;
        logic [7:0] e_stat;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1,3'd1,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h80,8'h80,8'h80,3'd1,8'h0C},
        '{1'b1,3'd1,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h80,8'h80,8'h80,3'd2,8'h0C},
        '{1'b0,3'd0,2'd0,1'b1,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h80,3'd3,8'h0D},
        '{1'b0,3'd0,2'd0,1'b1,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h80,3'd4,8'h0D},
        '{1'b1,3'd1,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h80,8'h02,8'h80,8'h80,3'd4,8'h05},
        '{1'b0,3'd0,2'd0,1'b1,1'b0,1'b0,8'h00, 8'h80,8'h02,8'h80,8'h80,3'd4,8'h05},
        '{1'b1,3'd5,2'd1,1'b0,1'b0,1'b0,8'h00, 8'h80,8'h02,8'h80,8'h80,3'd3,8'h05},
        '{1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h80,3'd4,8'h0D},
        '{1'b1,3'd6,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h00,8'h80,3'd4,8'h0D},
        '{1'b0,3'd0,2'd0,1'b0,1'b0,1'b1,8'h04, 8'h01,8'h02,8'h00,8'h80,3'd4,8'h09},
        '{1'b0,3'd0,2'd0,1'b0,1'b1,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h00,3'd4,8'h0F},
        '{1'b0,3'd0,2'd0,1'b0,1'b0,1'b1,8'hFF, 8'h01,8'h02,8'h80,8'h80,3'd4,8'h0D},
        '{1'b1,3'd3,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h03,8'h80,8'h80,3'd4,8'h0D},
        '{1'b1,3'd4,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h80,8'h80,8'h80,3'd3,8'h0C},
        '{1'b1,3'd4,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h80,8'h80,8'h80,3'd3,8'h0C},
        '{1'b1,3'd2,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h80,8'h80,8'h80,3'd0,8'h0C},
        '{1'b0,3'd0,2'd0,1'b1,1'b0,1'b0,8'h00, 8'h00,8'h00,8'h80,8'h80,3'd1,8'h0D},
        '{1'b1,3'd6,2'd2,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00,8'h02,8'h80,3'd1,8'h0D},
        '{1'b1,3'd7,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00,8'h80,8'h80,3'd1,8'h0D},
        '{1'b1,3'd0,2'd0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00,8'h80,8'h80,3'd1,8'h0D}
    };

    function automatic string rtag(input int i);
        case (i)
            0, 1:          return "R1 lowest free page";
            2, 3, 5, 16:   return "R4 receive page request";
            4, 6, 7:       return "R2 pending allocation";
            8, 17, 18, 19: return "R3 command decode";
            9, 11:         return "R9 acknowledge";
            10:            return "R6 transmit done";
            12, 13, 14:    return "R5 receive pop";
            default:       return "R12 unit reset";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_we = 1'b0; cmd_code = '0; pkt_num = '0; rx_req = 1'b0; tx_sent = 1'b0;
        ack_we = 1'b0; ack_wdata = '0; mask_we = 1'b0; mask_wdata = '0;
    endtask

    // Inputs are set at a falling edge, held over one rising edge, then cleared.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic cmd(input logic [2:0] c, input logic [1:0] p);
        cmd_we = 1'b1; cmd_code = c; pkt_num = p;
        step();
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R11 heads"}, {40'h0, alloc_result, rx_head, tx_head},
              {40'h0, 8'h00, 8'h80, 8'h80});
        check({tag, " R11 done/used"}, {48'h0, done_head, 5'd0, pages_used},
              {48'h0, 8'h80, 8'h00});
        check({tag, " R11 status/mask/irq"}, {39'h0, int_status, int_mask, 7'd0, irq},
              {39'h0, 8'h04, 8'h00, 8'h00});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R11: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("initial");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            cmd_we    = VEC[i].cv;
            cmd_code  = VEC[i].code;
            pkt_num   = VEC[i].pkt;
            rx_req    = VEC[i].rx;
            tx_sent   = VEC[i].ts;
            ack_we    = VEC[i].av;
            ack_wdata = VEC[i].ack;
            step();
            check($sformatf("row %0d %s", i, rtag(i)),
                  {21'h0, alloc_result, rx_head, tx_head, done_head, pages_used, int_status},
                  {21'h0, VEC[i].e_alloc, VEC[i].e_rx, VEC[i].e_tx, VEC[i].e_done,
                   VEC[i].e_used, VEC[i].e_stat});
        end

        // R10: mask gating of the interrupt line (status is 0x0D here)
        mask_we = 1'b1; mask_wdata = 8'h02; step();
        check("R10 masked-out irq", {55'h0, int_mask, irq}, {55'h0, 8'h02, 1'b0});
        mask_we = 1'b1; mask_wdata = 8'h08; step();
        check("R10 unmasked irq", {55'h0, int_mask, irq}, {55'h0, 8'h08, 1'b1});

        // R7: fifth push into a full transmit queue is dropped
        cmd(3'd6, 2'd0); cmd(3'd6, 2'd1); cmd(3'd6, 2'd2); cmd(3'd6, 2'd3); cmd(3'd1 + 3'd5, 2'd0);
        check("R7 head after fill", {56'h0, tx_head}, {56'h0, 8'h00});
        tx_sent = 1'b1; step();
        check("R7 pop 1", {48'h0, tx_head, done_head}, {48'h0, 8'h01, 8'h00});
        tx_sent = 1'b1; step();
        tx_sent = 1'b1; step();
        check("R7 pop 3", {56'h0, tx_head}, {56'h0, 8'h03});
        tx_sent = 1'b1; step();
        check("R7 extra push dropped", {56'h0, tx_head}, {56'h0, 8'h80});
        // R9: one acknowledge of the TX bit removes one entry only
        ack_we = 1'b1; ack_wdata = 8'h02; step();
        check("R9 single done pop", {48'h0, done_head, int_status}, {48'h0, 8'h01, 8'h0F});
        cmd(3'd7, 2'd0);
        check("R3 clear tx queues", {48'h0, tx_head, done_head}, {48'h0, 8'h80, 8'h80});

        // R6: auto release frees the sent page instead of queueing it
        cmd(3'd1, 2'd0);
        check("R1 next lowest page", {53'h0, alloc_result, pages_used}, {53'h0, 8'h01, 3'd2});
        cmd(3'd6, 2'd1);
        auto_release = 1'b1; tx_sent = 1'b1; step();
        auto_release = 1'b0;
        check("R6 auto release", {45'h0, tx_head, done_head, pages_used},
              {45'h0, 8'h80, 8'h80, 3'd1});

        // R4: pending transmit allocation beats a receive request on wake-up
        cmd(3'd1, 2'd0);
        rx_req = 1'b1; step();
        rx_req = 1'b1; step();
        check("R4 pool filled", {53'h0, alloc_result, pages_used}, {53'h0, 8'h01, 3'd4});
        cmd(3'd1, 2'd0);
        cmd(3'd5, 2'd2);
        check("R2 still pending after free", {53'h0, alloc_result, pages_used},
              {53'h0, 8'h80, 3'd3});
        rx_req = 1'b1; step();
        check("R4 transmit wins freed page", {45'h0, alloc_result, rx_head, pages_used},
              {45'h0, 8'h02, 8'h00, 3'd4});
        cmd(3'd3, 2'd0);
        cmd(3'd3, 2'd0);
        cmd(3'd3, 2'd0);
        check("R4 receive request dropped", {56'h0, rx_head}, {56'h0, 8'h80});

        // R11: reset in the middle of activity
        rst = 1'b1; step(); rst = 1'b0;
        check_reset_state("mid-run");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule